// File: doc/BRIEF.md
# Burst ADC Conversion Sequencer

This block sits between a system-clock register interface and a successive-approximation converter. It turns a convert-start pulse into a series of power-up, track and convert requests, and sums the 12-bit samples that the converter returns. After the programmed number of samples it publishes the 16-bit sum. At the same moment it raises a sticky end-of-conversion flag and a one-cycle result strobe. The same strobe gates a downstream window comparator.

The sequencer runs on its own fast burst clock. The system clock can therefore be slow and still see a full multi-sample burst complete within a few of its own cycles. A start crosses into the burst domain through a toggle synchronizer, and the completion notice returns the same way. In burst mode one start runs every conversion of the accumulation. In single mode each conversion needs its own start, and the accumulation still spans the programmed count. Between bursts the converter either powers down or stays idle. A start that finds it powered down first waits a programmable number of burst clocks.

The configuration inputs (`bst_en_i`, `idle_on_i`, `dual_trk_i`, `rep_sel_i`, `pwr_dly_i`) are quasi-static. They must hold steady while an accumulation is in progress.

Top module: `adc_burst_seq`

## Requirements
- R1: `rep_sel_i` selects the number of samples summed per result: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. `acc_o` is the 16-bit sum of exactly that many 12-bit samples.
- R2: With `bst_en_i`=1, one accepted start produces exactly the selected number of conversion requests, back to back.
- R3: With `bst_en_i`=0, each accepted start produces exactly one conversion. `eoc_o` stays 0 until the conversion that completes the count.
- R4: On completion, `res_valid_o` and `win_en_o` pulse high together for one system clock, and `eoc_o` goes to 1. `eoc_o` stays 1 until a one-cycle `eoc_clr_i` pulse clears it.
- R5: Each new accumulation starts from zero. A result never includes samples from the previous result.
- R6: After a burst, `pwr_on_o` is 0 if `idle_on_i`=0 and 1 if `idle_on_i`=1. After a single-mode conversion, the converter stays powered.
- R7: A start that finds the converter powered down raises `pwr_on_o`. In post-tracking mode (`dual_trk_i`=0), `track_o` is first asserted after exactly `pwr_dly_i`+1 burst clocks. A start that finds the converter powered does not repeat the power-up.
- R8: In dual-tracking mode (`dual_trk_i`=1), `track_o` is high from the first cycle of the power-up period.
- R9: In burst mode, a start that arrives fewer than four system clocks after the previously accepted start pulses `start_err_o` and launches nothing.
- R10: A start that arrives while an accumulation run is in flight has no effect.
- R11: After reset all outputs are 0, and the converter is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| bst_clk | input | 1 | Fast burst clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| start_i | input | 1 | Convert-start pulse (system clock) |
| bst_en_i | input | 1 | 1 = burst mode, 0 = one conversion per start |
| idle_on_i | input | 1 | Idle power select: 1 = stay powered after a burst |
| dual_trk_i | input | 1 | 1 = dual tracking, 0 = post tracking |
| rep_sel_i | input | 2 | Repeat-count select (1/4/8/16) |
| pwr_dly_i | input | 4 | Power-up wait in burst clocks, minus one |
| eoc_clr_i | input | 1 | Write-one-to-clear pulse for the end-of-conversion flag |
| pwr_on_o | output | 1 | Converter power request |
| track_o | output | 1 | Converter track request |
| conv_req_o | output | 1 | Converter convert request, held until done |
| conv_done_i | input | 1 | Converter done strobe (burst clock) |
| conv_data_i | input | 12 | Converter sample, valid with done |
| acc_o | output | 16 | Accumulated result |
| eoc_o | output | 1 | Sticky end-of-conversion flag |
| res_valid_o | output | 1 | One-cycle result strobe |
| win_en_o | output | 1 | Window-compare enable, one cycle per result |
| start_err_o | output | 1 | Pulse: start rejected for spacing |

## Verification
The bench runs a table of mode mixes in sequence, so each case starts from whatever power state the previous one left behind. A design that always re-powers, or never powers down, therefore fails the power-up-length and idle-state checks. A sixteen-sample run of all-ones samples shows whether the accumulator is too narrow. Running back-to-back results shows whether a design forgets to clear the sum between accumulations. In single mode the bench checks the flag before the last start, which catches a design that raises it on every sample. The bench also sends starts at two- and four-cycle spacing during a burst. The first must flag an error. The second must be dropped silently, without adding conversions.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;
    localparam int SMP_W   = 12;
    localparam int ACC_W   = 16;
    localparam int MAX_REP = 16;
    localparam int REP_W   = $clog2(MAX_REP + 1);

    typedef enum logic [2:0] {
        S_OFF, S_PWRUP, S_TRACK, S_CONV, S_IDLE
    } seq_state_e;

    function automatic logic [REP_W-1:0] rep_count(input logic [1:0] sel);
        case (sel)
            2'd0:    rep_count = REP_W'(1);
            2'd1:    rep_count = REP_W'(4);
            2'd2:    rep_count = REP_W'(8);
            default: rep_count = REP_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/adc_burst_sync.sv
module adc_burst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic pulse_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], tog_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/adc_burst_core.sv
module adc_burst_core
    import adc_burst_pkg::*;
#(
    parameter int PD_W      = 4,
    parameter int TRACK_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_p_i,
    input  logic             bst_en_i,
    input  logic             idle_on_i,
    input  logic             dual_trk_i,
    input  logic [1:0]       rep_sel_i,
    input  logic [PD_W-1:0]  pwr_dly_i,
    input  logic             conv_done_i,
    input  logic [SMP_W-1:0] conv_data_i,
    output logic             pwr_on_o,
    output logic             track_o,
    output logic             conv_req_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             cmpl_o,
    output logic             ack_tog_o
);
    localparam int TW = $clog2(TRACK_CYC + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [PD_W-1:0]  dcnt;
        logic [TW-1:0]    tcnt;
        logic [REP_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic             cmpl;
        logic             ack;
    } core_s;

    core_s d, q;
    logic [REP_W-1:0] reps;
    logic run_end;

    always_comb begin
        reps    = rep_count(rep_sel_i);
        d       = q;
        run_end = 1'b0;
        case (q.state)
            S_OFF, S_IDLE: begin
                if (start_p_i) begin
                    if (q.cnt == '0) d.acc = '0;
                    d.cmpl = 1'b0;
                    if (q.state == S_OFF) begin
                        d.state = S_PWRUP;
                        d.dcnt  = pwr_dly_i;
                    end else begin
                        d.state = S_TRACK;
                        d.tcnt  = TW'(TRACK_CYC - 1);
                    end
                end
            end
            S_PWRUP: begin
                if (q.dcnt == '0) begin
                    d.state = S_TRACK;
                    d.tcnt  = TW'(TRACK_CYC - 1);
                end else begin
                    d.dcnt = q.dcnt - 1'b1;
                end
            end
            S_TRACK: begin
                if (q.tcnt == '0) d.state = S_CONV;
                else              d.tcnt  = q.tcnt - 1'b1;
            end
            S_CONV: begin
                if (conv_done_i) begin
                    d.acc = q.acc + ACC_W'(conv_data_i);
                    if (q.cnt == reps - 1'b1) begin
                        d.cnt   = '0;
                        d.cmpl  = 1'b1;
                        run_end = 1'b1;
                    end else begin
                        d.cnt   = q.cnt + 1'b1;
                        run_end = !bst_en_i;
                    end
                    if (run_end) begin
                        d.ack   = ~q.ack;
                        d.state = (bst_en_i && !idle_on_i) ? S_OFF : S_IDLE;
                    end else begin
                        d.state = S_TRACK;
                        d.tcnt  = TW'(TRACK_CYC - 1);
                    end
                end
            end
            default: d.state = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= S_OFF;
            q.dcnt  <= '0;
            q.tcnt  <= '0;
            q.cnt   <= '0;
            q.acc   <= '0;
            q.cmpl  <= 1'b0;
            q.ack   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pwr_on_o   = (q.state != S_OFF);
    assign track_o    = (q.state == S_TRACK) || (q.state == S_PWRUP && dual_trk_i);
    assign conv_req_o = (q.state == S_CONV);
    assign acc_o      = q.acc;
    assign cmpl_o     = q.cmpl;
    assign ack_tog_o  = q.ack;

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < REP_W'(MAX_REP));

    // R4
    cmpl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_CONV && conv_done_i && q.cnt == reps - 1'b1) |=> (q.cmpl && $changed(q.ack)));
endmodule

// File: rtl/adc_burst_sys.sv
module adc_burst_sys
    import adc_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bst_en_i,
    input  logic             eoc_clr_i,
    input  logic             ack_p_i,
    input  logic             cmpl_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             start_tog_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             eoc_o,
    output logic             res_valid_o,
    output logic             win_en_o,
    output logic             start_err_o
);
    localparam logic [1:0] GAP_OK = 2'd3;

    typedef struct packed {
        logic [1:0]       gap;
        logic             busy;
        logic             tog;
        logic [ACC_W-1:0] acc;
        logic             eoc;
        logic             valid;
        logic             err;
    } sys_s;

    sys_s d, q;
    logic start_ok;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (q.gap != GAP_OK) d.gap = q.gap + 1'b1;
        if (ack_p_i) begin
            d.busy = 1'b0;
            if (cmpl_i) begin
                d.acc   = acc_i;
                d.valid = 1'b1;
            end
        end
        if (eoc_clr_i)         d.eoc = 1'b0;
        if (ack_p_i && cmpl_i) d.eoc = 1'b1;
        d.err    = start_i && bst_en_i && (q.gap != GAP_OK);
        start_ok = start_i && !q.busy && !d.err;
        if (start_ok) begin
            d.busy = 1'b1;
            d.tog  = ~q.tog;
            d.gap  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.gap   <= GAP_OK;
            q.busy  <= 1'b0;
            q.tog   <= 1'b0;
            q.acc   <= '0;
            q.eoc   <= 1'b0;
            q.valid <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign start_tog_o = q.tog;
    assign acc_o       = q.acc;
    assign eoc_o       = q.eoc;
    assign res_valid_o = q.valid;
    assign win_en_o    = q.valid;
    assign start_err_o = q.err;

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> q.busy);

    // R4
    valid_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> q.eoc);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R9
    err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> $stable(q.tog));
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
    import adc_burst_pkg::*;
#(
    parameter int PD_W      = 4,
    parameter int TRACK_CYC = 2,
    parameter int SYNC_STG  = 2
) (
    input  logic             sys_clk,
    input  logic             bst_clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bst_en_i,
    input  logic             idle_on_i,
    input  logic             dual_trk_i,
    input  logic [1:0]       rep_sel_i,
    input  logic [PD_W-1:0]  pwr_dly_i,
    input  logic             eoc_clr_i,
    output logic             pwr_on_o,
    output logic             track_o,
    output logic             conv_req_o,
    input  logic             conv_done_i,
    input  logic [SMP_W-1:0] conv_data_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             eoc_o,
    output logic             res_valid_o,
    output logic             win_en_o,
    output logic             start_err_o
);
    logic             start_tog, start_p, ack_tog, ack_p, cmpl;
    logic [ACC_W-1:0] core_acc;

    adc_burst_sync #(.STAGES(SYNC_STG)) u_start_sync (
        .clk(bst_clk), .rst_n(rst_n), .tog_i(start_tog), .pulse_o(start_p)
    );

    adc_burst_core #(.PD_W(PD_W), .TRACK_CYC(TRACK_CYC)) u_core (
        .clk(bst_clk), .rst_n(rst_n), .start_p_i(start_p),
        .bst_en_i(bst_en_i), .idle_on_i(idle_on_i), .dual_trk_i(dual_trk_i),
        .rep_sel_i(rep_sel_i), .pwr_dly_i(pwr_dly_i),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .pwr_on_o(pwr_on_o), .track_o(track_o), .conv_req_o(conv_req_o),
        .acc_o(core_acc), .cmpl_o(cmpl), .ack_tog_o(ack_tog)
    );

    adc_burst_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(sys_clk), .rst_n(rst_n), .tog_i(ack_tog), .pulse_o(ack_p)
    );

    adc_burst_sys u_sys (
        .clk(sys_clk), .rst_n(rst_n), .start_i(start_i), .bst_en_i(bst_en_i),
        .eoc_clr_i(eoc_clr_i), .ack_p_i(ack_p), .cmpl_i(cmpl), .acc_i(core_acc),
        .start_tog_o(start_tog), .acc_o(acc_o), .eoc_o(eoc_o),
        .res_valid_o(res_valid_o), .win_en_o(win_en_o), .start_err_o(start_err_o)
    );
endmodule

// File: tb/tb_adc_burst_seq.sv
module tb_adc_burst_seq;
    localparam int CLK_PERIOD  = 10;
    localparam int BCLK_PERIOD = 4;
    localparam int CONV_LAT    = 3;
    localparam int WD_LIMIT    = 150000;
    localparam int NVEC        = 6;
    // {bst, idle, dual, rep[1:0], pd[3:0], seed[11:0], step[11:0]}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 2'd1, 4'd5, 12'h064, 12'h101},
        {1'b1, 1'b1, 1'b1, 2'd2, 4'd3, 12'h800, 12'h0F3},
        {1'b1, 1'b0, 1'b0, 2'd3, 4'd2, 12'h123, 12'h321},
        {1'b0, 1'b0, 1'b0, 2'd1, 4'd7, 12'h7FF, 12'h555},
        {1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 12'hABC, 12'h000},
        {1'b1, 1'b0, 1'b0, 2'd3, 4'd1, 12'hFFF, 12'h000}
    };

    logic sys_clk = 1'b0, bst_clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, bst_en_i = 1'b0, idle_on_i = 1'b0, dual_trk_i = 1'b0;
    logic [1:0] rep_sel_i = '0;
    logic [3:0] pwr_dly_i = '0;
    logic eoc_clr_i = 1'b0, conv_done_i = 1'b0;
    logic [11:0] conv_data_i = '0;
    logic pwr_on_o, track_o, conv_req_o, eoc_o, res_valid_o, win_en_o, start_err_o;
    logic [15:0] acc_o;

    int checks = 0, failures = 0, cyc = 0;
    int conv_cnt = 0, wait_cnt = 0, smp_k = 0;
    logic [11:0] cur_seed = '0, cur_step = '0;
    bit pwr_prev = 0, pu_meas = 0, pu_seen = 0;
    int pu_cnt = 0;

    always #(CLK_PERIOD/2)  sys_clk = ~sys_clk;
    always #(BCLK_PERIOD/2) bst_clk = ~bst_clk;

    adc_burst_seq dut (
        .sys_clk(sys_clk), .bst_clk(bst_clk), .rst_n(rst_n), .start_i(start_i),
        .bst_en_i(bst_en_i), .idle_on_i(idle_on_i), .dual_trk_i(dual_trk_i),
        .rep_sel_i(rep_sel_i), .pwr_dly_i(pwr_dly_i), .eoc_clr_i(eoc_clr_i),
        .pwr_on_o(pwr_on_o), .track_o(track_o), .conv_req_o(conv_req_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i), .acc_o(acc_o),
        .eoc_o(eoc_o), .res_valid_o(res_valid_o), .win_en_o(win_en_o),
        .start_err_o(start_err_o)
    );

    function automatic logic [11:0] smp(input int k);
        return cur_seed + 12'(k) * cur_step;
    endfunction

    // converter model and power-up meter, away from the active edge
    always @(negedge bst_clk) begin
        if (conv_done_i) begin
            conv_done_i = 1'b0;
            wait_cnt    = 0;
        end else if (conv_req_o) begin
            if (wait_cnt == CONV_LAT - 1) begin
                conv_data_i = smp(smp_k);
                conv_done_i = 1'b1;
                smp_k++;
                conv_cnt++;
            end else begin
                wait_cnt++;
            end
        end
        if (!pwr_prev && pwr_on_o) begin
            pu_seen = 1;
            pu_meas = !track_o;
            pu_cnt  = track_o ? 0 : 1;
        end else if (pu_meas) begin
            if (track_o) pu_meas = 0;
            else         pu_cnt++;
        end
        pwr_prev = pwr_on_o;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge sys_clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge sys_clk) start_i = 1'b1;
        @(negedge sys_clk) start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 4000 && !got; i++) begin
            @(negedge sys_clk);
            if (res_valid_o) begin
                got = 1;
                chk(win_en_o == 1'b1, "R4 window enable with strobe", win_en_o, 1);
            end
        end
    endtask

    initial begin
        bit powered, got, bst, idle, dual;
        logic [1:0] rs;
        logic [3:0] pd;
        int reps;
        logic [15:0] exp_sum;

        repeat (4) @(negedge sys_clk);
        // R11 reset state
        chk({pwr_on_o, track_o, conv_req_o, eoc_o, res_valid_o, win_en_o, start_err_o} == 7'd0,
            "R11 reset outputs", {pwr_on_o, track_o, conv_req_o, eoc_o, res_valid_o, win_en_o, start_err_o}, 0);
        chk(acc_o == 16'd0, "R11 reset acc", acc_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        powered = 0;

        for (int v = 0; v < NVEC; v++) begin
            {bst, idle, dual, rs, pd, cur_seed, cur_step} = VEC[v];
            bst_en_i = bst; idle_on_i = idle; dual_trk_i = dual;
            rep_sel_i = rs; pwr_dly_i = pd;
            reps = (rs == 0) ? 1 : (rs == 1) ? 4 : (rs == 2) ? 8 : 16;
            exp_sum = '0;
            for (int k = 0; k < reps; k++) exp_sum += 16'(smp(k));
            @(negedge sys_clk) eoc_clr_i = 1'b1;
            @(negedge sys_clk) eoc_clr_i = 1'b0;
            repeat (6) @(negedge sys_clk);
            conv_cnt = 0; smp_k = 0; pu_seen = 0;
            if (bst) begin
                pulse_start();
                wait_valid(got);
                chk(conv_cnt == reps, "R2 conversions per burst start", conv_cnt, reps);
            end else begin
                for (int s = 0; s < reps; s++) begin
                    if (s == reps - 1)
                        chk(eoc_o == 1'b0, "R3 flag low before last sample", eoc_o, 0);
                    pulse_start();
                    if (s < reps - 1) begin
                        for (int t = 0; t < 2000 && conv_cnt != s + 1; t++) @(negedge sys_clk);
                        repeat (10) @(negedge sys_clk);
                        chk(conv_cnt == s + 1, "R3 one conversion per start", conv_cnt, s + 1);
                    end
                end
                wait_valid(got);
                chk(conv_cnt == reps, "R3 conversions in single mode", conv_cnt, reps);
            end
            chk(got, "R4 result strobe seen", got, 1);
            // R1 and R5: sum over exactly reps samples, started from zero
            chk(acc_o == exp_sum, "R1 R5 accumulated sum", acc_o, exp_sum);
            repeat (3) @(negedge sys_clk);
            chk(eoc_o == 1'b1, "R4 flag held after result", eoc_o, 1);
            if (!powered) begin
                chk(pu_seen, "R7 power-up occurred", pu_seen, 1);
                if (dual) chk(pu_cnt == 0, "R8 track during power-up", pu_cnt, 0);
                else      chk(pu_cnt == int'(pd) + 1, "R7 power-up wait", pu_cnt, int'(pd) + 1);
            end else begin
                chk(!pu_seen, "R7 no power-up when already on", pu_seen, 0);
            end
            powered = !bst || idle;
            chk(pwr_on_o == powered, "R6 idle power state", pwr_on_o, powered);
        end

        // R9 / R10: close starts during a burst
        bst_en_i = 1'b1; idle_on_i = 1'b1; dual_trk_i = 1'b0; rep_sel_i = 2'd1; pwr_dly_i = 4'd0;
        cur_seed = 12'h010; cur_step = 12'h001;
        conv_cnt = 0; smp_k = 0;
        repeat (6) @(negedge sys_clk);
        @(negedge sys_clk) start_i = 1'b1;
        @(negedge sys_clk) start_i = 1'b0;
        @(negedge sys_clk) start_i = 1'b1;
        @(negedge sys_clk) start_i = 1'b0;
        chk(start_err_o == 1'b1, "R9 error on start two cycles later", start_err_o, 1);
        @(negedge sys_clk) start_i = 1'b1;
        @(negedge sys_clk) start_i = 1'b0;
        chk(start_err_o == 1'b0, "R9 no error at four-cycle spacing", start_err_o, 0);
        wait_valid(got);
        repeat (20) @(negedge sys_clk);
        chk(conv_cnt == 4, "R10 extra starts ignored", conv_cnt, 4);
        chk(acc_o == 16'h0046, "R10 sum unaffected", acc_o, 16'h0046);

        // R4 clear
        chk(eoc_o == 1'b1, "R4 flag set before clear", eoc_o, 1);
        @(negedge sys_clk) eoc_clr_i = 1'b1;
        @(negedge sys_clk) eoc_clr_i = 1'b0;
        chk(eoc_o == 1'b0, "R4 flag cleared by pulse", eoc_o, 0);
        chk(res_valid_o == 1'b0, "R4 no strobe on clear", res_valid_o, 0);

        summary();
    end
endmodule